// File: doc/BRIEF.md
# Hybrid Rate-Latency Spike Encoder

This block turns a vector of unsigned input intensities into binary spike trains that last a fixed number of timesteps. Each channel keeps its own accumulator. The accumulator grows by the channel's input at every timestep, and the channel fires when the accumulator reaches a firing threshold. That threshold is the shared base threshold, scaled down by the channel's own input through a configurable gain. One mechanism therefore carries both a latency code and a rate code: a strong input fires sooner and also fires more often across the window.

A single-cycle start pulse captures the input vector, the base threshold, the gain and the window length, and clears every accumulator. Each later cycle is one timestep. In that cycle the block emits a spike vector together with a one-cycle valid strobe. When the window has been played out, a done flag rises and stays high until the next start.

Top module: `spike_encoder`

## Requirements
- R1: The threshold of channel c is max(1, floor(B * (65536 - G*x_c) / 65536)). B is the 12-bit base threshold, G is the 8-bit gain read as a fraction of 256, and x_c is the 8-bit input read as a fraction of 256. The threshold is never zero, even when B is 0 or G*x_c is close to 65536.
- R2: At each timestep a channel forms the potential p = acc + x_c. It spikes exactly when p >= threshold. After a spike the accumulator becomes p - threshold; otherwise it becomes p. A channel spikes at most once per timestep.
- R3: A start pulse captures in_vec, cfg_base, cfg_gain and cfg_window, sets every accumulator to zero and clears done. A start that arrives during a window abandons that window, and the new window begins from zero.
- R4: If start is sampled high on clock edge E0, spike vectors for timesteps 0..W-1 appear on the outputs after edges E1..EW, one per cycle, each with spk_valid high for that cycle. Outside those cycles spk_valid is 0 and spk_vec is all zeros.
- R5: done rises after edge E(W+1), one cycle after the last valid strobe. It is never high together with spk_valid, and it holds until the next start.
- R6: A channel whose input is zero never spikes.
- R7: With the same configuration, a larger input gives a first spike that is no later and a spike count that is no smaller. Over the default window, a channel at input 255 fires strictly more often than a channel at input 16.
- R8: A cfg_window value of 0 selects the default window of 20 timesteps. Any other value v gives v timesteps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that captures inputs and configuration and begins a window |
| in_vec | input | NCH*DW | Channel intensities, channel c at bits [c*DW +: DW] |
| cfg_base | input | THW | Base firing threshold |
| cfg_gain | input | GW | Threshold modulation gain, fraction of 256 |
| cfg_window | input | WINW | Timesteps per window, 0 selects the default |
| spk_vec | output | NCH | Spike vector of the current timestep, bit c for channel c |
| spk_valid | output | 1 | High for one cycle per timestep |
| done | output | 1 | High once the window has completed, until the next start |

## Verification
Two functions can fall in the same cycle: a new start and an ongoing timestep. A start takes priority over the step, so the accumulators clear instead of advancing. The bench provokes this by issuing a fresh start a few timesteps into a running window, using different inputs. It then compares every spike vector of the new window with a model that begins from zero accumulators. The bench also checks that the first cycle after the start shows neither a valid strobe nor done, and a checker property covers the same condition on every start.

// File: rtl/spk_pkg.sv
package spk_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/spk_thresh.sv
module spk_thresh #(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int GW  = 8,
    parameter int THW = 12
) (
    input  logic [NCH*DW-1:0]  x_flat,
    input  logic [THW-1:0]     base,
    input  logic [GW-1:0]      gain,
    output logic [NCH*THW-1:0] thr_flat
);
    localparam int PW = GW + DW;
    localparam int SW = PW + 1;
    localparam int FW = THW + SW;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [PW-1:0]  prod;
        logic [SW-1:0]  scale;
        logic [FW-1:0]  full;
        logic [FW-1:0]  shifted;
        logic [THW-1:0] raw;
        logic [THW-1:0] thr_c;

        always_comb begin
            prod    = PW'(gain) * PW'(x_flat[c*DW +: DW]);
            scale   = (SW'(1) << PW) - SW'(prod);
            full    = FW'(base) * FW'(scale);
            shifted = full >> PW;
            raw     = shifted[THW-1:0];
            // floor of one LSB keeps a channel from firing on nothing
            thr_c   = (raw == '0) ? THW'(1) : raw;
        end

        assign thr_flat[c*THW +: THW] = thr_c;
    end
endmodule

// File: rtl/spk_chan.sv
module spk_chan #(
    parameter int DW   = 8,
    parameter int THW  = 12,
    parameter int ACCW = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           tick,
    input  logic [DW-1:0]  x,
    input  logic [THW-1:0] thr,
    output logic           spike
);
    typedef struct packed {
        logic [ACCW-1:0] acc;
        logic            spk;
    } chan_t;

    chan_t           chan_d, chan_q;
    logic [ACCW-1:0] pot;
    logic            fire;

    always_comb begin
        chan_d     = chan_q;
        chan_d.spk = 1'b0;
        pot        = chan_q.acc + ACCW'(x);
        fire       = (pot >= ACCW'(thr));
        if (clr) begin
            chan_d.acc = '0;
        end else if (tick) begin
            chan_d.spk = fire;
            // residue above threshold carries into the next timestep
            chan_d.acc = fire ? (pot - ACCW'(thr)) : pot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chan_q <= '0;
        else        chan_q <= chan_d;
    end

    assign spike = chan_q.spk;
endmodule

// File: rtl/spk_seq.sv
module spk_seq #(
    parameter int WINW    = 8,
    parameter int DEF_WIN = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WINW-1:0] cfg_window,
    output logic            tick,
    output logic            valid,
    output logic            done
);
    import spk_pkg::*;

    typedef struct packed {
        phase_e          ph;
        logic [WINW-1:0] step;
        logic [WINW-1:0] win;
        logic            valid;
        logic            done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic in_window;

    always_comb begin
        in_window   = (seq_q.ph == PH_RUN) && (seq_q.step < seq_q.win);
        tick        = in_window && !start;
        seq_d       = seq_q;
        seq_d.valid = 1'b0;
        if (start) begin
            seq_d.ph   = PH_RUN;
            seq_d.step = '0;
            seq_d.win  = (cfg_window == '0) ? WINW'(DEF_WIN) : cfg_window;
            seq_d.done = 1'b0;
        end else if (seq_q.ph == PH_RUN) begin
            if (in_window) begin
                seq_d.valid = 1'b1;
                seq_d.step  = seq_q.step + 1'b1;
            end else begin
                seq_d.ph   = PH_IDLE;
                seq_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, step: '0, win: '0, valid: 1'b0, done: 1'b0};
        else        seq_q <= seq_d;
    end

    assign valid = seq_q.valid;
    assign done  = seq_q.done;
endmodule

// File: rtl/spike_encoder.sv
module spike_encoder #(
    parameter int NCH     = 8,
    parameter int DW      = 8,
    parameter int GW      = 8,
    parameter int THW     = 12,
    parameter int WINW    = 8,
    parameter int DEF_WIN = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NCH*DW-1:0] in_vec,
    input  logic [THW-1:0]    cfg_base,
    input  logic [GW-1:0]     cfg_gain,
    input  logic [WINW-1:0]   cfg_window,
    output logic [NCH-1:0]    spk_vec,
    output logic              spk_valid,
    output logic              done
);
    localparam int ACC_MIN = DW + WINW + 1;
    localparam int ACCW    = (ACC_MIN > THW + 1) ? ACC_MIN : THW + 1;

    typedef struct packed {
        logic [NCH*DW-1:0] x;
        logic [THW-1:0]    base;
        logic [GW-1:0]     gain;
    } lat_t;

    lat_t               lat_d, lat_q;
    logic [NCH*DW-1:0]  x_flat;
    logic [NCH*THW-1:0] thr_flat;
    logic               tick;

    always_comb begin
        lat_d = lat_q;
        if (start) begin
            lat_d.x    = in_vec;
            lat_d.base = cfg_base;
            lat_d.gain = cfg_gain;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign x_flat = lat_q.x;

    spk_seq #(.WINW(WINW), .DEF_WIN(DEF_WIN)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_window (cfg_window),
        .tick       (tick),
        .valid      (spk_valid),
        .done       (done)
    );

    spk_thresh #(.NCH(NCH), .DW(DW), .GW(GW), .THW(THW)) u_thresh (
        .x_flat   (x_flat),
        .base     (lat_q.base),
        .gain     (lat_q.gain),
        .thr_flat (thr_flat)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        spk_chan #(.DW(DW), .THW(THW), .ACCW(ACCW)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (start),
            .tick  (tick),
            .x     (x_flat[c*DW +: DW]),
            .thr   (thr_flat[c*THW +: THW]),
            .spike (spk_vec[c])
        );
    end
endmodule

// File: rtl/spike_encoder_chk.sv
module spike_encoder_chk #(
    parameter int NCH = 8,
    parameter int DW  = 8,
    parameter int THW = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [NCH-1:0]     spk_vec,
    input logic               spk_valid,
    input logic               done,
    input logic [NCH*DW-1:0]  x_flat,
    input logic [NCH*THW-1:0] thr_flat
);
    p_quiet_between_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !spk_valid |-> (spk_vec == '0));

    p_done_not_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && spk_valid));

    p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!spk_valid && !done));

    p_done_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_done_after_last_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(spk_valid));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        p_thr_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
            thr_flat[c*THW +: THW] != '0);

        p_zero_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (spk_valid && (x_flat[c*DW +: DW] == '0)) |-> !spk_vec[c]);
    end
endmodule

bind spike_encoder spike_encoder_chk #(.NCH(NCH), .DW(DW), .THW(THW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .spk_vec   (spk_vec),
    .spk_valid (spk_valid),
    .done      (done),
    .x_flat    (x_flat),
    .thr_flat  (thr_flat)
);

// File: tb/spike_encoder_bench.sv
module spike_encoder_bench;
    localparam int NCH  = 8;
    localparam int DW   = 8;
    localparam int GW   = 8;
    localparam int THW  = 12;
    localparam int WINW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NCH*DW-1:0] in_vec = '0;
    logic [THW-1:0]    cfg_base = '0;
    logic [GW-1:0]     cfg_gain = '0;
    logic [WINW-1:0]   cfg_window = '0;
    logic [NCH-1:0]    spk_vec;
    logic              spk_valid;
    logic              done;

    always #2 clk = ~clk;

    spike_encoder u_spike_encoder (
        .clk(clk), .rst_n(rst_n), .start(start), .in_vec(in_vec),
        .cfg_base(cfg_base), .cfg_gain(cfg_gain), .cfg_window(cfg_window),
        .spk_vec(spk_vec), .spk_valid(spk_valid), .done(done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    int cur_x[NCH];
    int first_sp[NCH];
    int cnt_sp[NCH];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int model_thr(input int x, input int base, input int gain);
        longint t;
        t = (longint'(base) * (65536 - gain * x)) >>> 16;
        if (t < 1) t = 1;
        return int'(t);
    endfunction

    // stop_at < 0 runs the whole window; otherwise returns after that many steps
    task automatic run_window(input int base, input int gain, input int wsel,
                              input int stop_at, input string tag);
        int w;
        int thr[NCH];
        int acc[NCH];
        logic [NCH-1:0] expv;
        w = (wsel == 0) ? 20 : wsel;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) in_vec[c*DW +: DW] = DW'(cur_x[c]);
        cfg_base   = THW'(base);
        cfg_gain   = GW'(gain);
        cfg_window = WINW'(wsel);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!spk_valid && !done, "R3 start cycle quiet", {spk_valid, done}, 0);
        for (int c = 0; c < NCH; c++) begin
            thr[c] = model_thr(cur_x[c], base, gain);
            acc[c] = 0;
            first_sp[c] = -1;
            cnt_sp[c] = 0;
        end
        for (int k = 0; k < w; k++) begin
            if (stop_at >= 0 && k == stop_at) return;
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                int p;
                p = acc[c] + cur_x[c];
                expv[c] = (p >= thr[c]);
                acc[c] = expv[c] ? p - thr[c] : p;
                if (spk_vec[c]) begin
                    cnt_sp[c]++;
                    if (first_sp[c] < 0) first_sp[c] = k;
                end
            end
            chk(spk_valid == 1'b1, "R4 valid per step", spk_valid, 1);
            chk(spk_vec == expv, {"R2 spikes ", tag}, spk_vec, expv);
        end
        @(negedge clk);
        chk(!spk_valid && done, (wsel == 0) ? "R8 default window end" : "R5 done after last step",
            {spk_valid, done}, 1);
        @(negedge clk);
        chk(done && spk_vec == '0, "R5 done holds", {done, spk_vec}, {1'b1, {NCH{1'b0}}});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(spk_valid == 0 && done == 0 && spk_vec == '0, "R4 reset state",
            {spk_valid, done, spk_vec}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: graded inputs, default window (R8)
        cur_x = '{0, 16, 48, 96, 128, 192, 224, 255};
        run_window(600, 128, 0, -1, "R7 graded");
        for (int c = 1; c < NCH - 1; c++) begin
            bit ok_first;
            ok_first = (first_sp[c] < 0) || (first_sp[c+1] >= 0 && first_sp[c+1] <= first_sp[c]);
            chk(ok_first, "R7 earlier first spike", first_sp[c+1], first_sp[c]);
            chk(cnt_sp[c+1] >= cnt_sp[c], "R7 count grows", cnt_sp[c+1], cnt_sp[c]);
        end
        chk(cnt_sp[7] > cnt_sp[1], "R7 strict rate", cnt_sp[7], cnt_sp[1]);
        chk(cnt_sp[0] == 0, "R6 zero input silent", cnt_sp[0], 0);

        // R1: threshold floor with base 0 and with full gain
        cur_x = '{0, 1, 2, 255, 255, 7, 0, 128};
        run_window(0, 37, 6, -1, "R1 base zero");
        chk(cnt_sp[1] == 6, "R1 floor fires each step", cnt_sp[1], 6);
        chk(cnt_sp[0] == 0, "R6 zero with unit threshold", cnt_sp[0], 0);
        run_window(1, 255, 5, -1, "R1 full gain");
        chk(cnt_sp[6] == 0, "R6 zero with full gain", cnt_sp[6], 0);

        // R3: restart inside a running window
        cur_x = '{200, 50, 90, 10, 255, 0, 33, 140};
        run_window(300, 64, 12, 5, "R3 first");
        cur_x = '{5, 250, 60, 180, 0, 99, 128, 17};
        run_window(400, 200, 9, -1, "R3 restart");

        // single timestep window
        run_window(150, 10, 1, -1, "R4 one step");

        // constrained random
        for (int r = 0; r < 25; r++) begin
            for (int c = 0; c < NCH; c++)
                cur_x[c] = ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(0, 255));
            run_window(int'($urandom_range(1, 700)), int'($urandom_range(0, 255)),
                       int'($urandom_range(0, 30)), -1, "random");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule